// File: doc/BRIEF.md
# Four-Bank Paired Instruction Fetch

This block is the data-read stage of an instruction store organised as four word-wide banks. Each cycle it may accept a pair of fetch addresses. It reads all four banks at the line picked by the first address and returns up to two instruction words one cycle later. Each word has its own valid flag. Address bits [3:2] pick the bank that holds a word. Both words can be delivered together only when the two addresses lie in the same 16-byte line, which means bits [31:4] are equal. Otherwise only the word for the first address is delivered.

A front end feeds the first slot with its primary fetch address, which may be a redirect after a misprediction. It feeds the second slot with either the sequential address or a predicted target. A pair that straddles a line boundary yields one word. The next pair then starts on that boundary, so sequential fetch realigns itself. A flush input drops whatever the stage would have delivered next, so that words fetched on a wrong path never leave the block.

Tags, misses and refill are outside this block. A small array stands in for the line storage, and it is loaded with a fixed pattern at reset.

A three-state controller tracks what the output register holds:
- `ST_EMPTY`: no word is held.
- `ST_ONE`: only the first slot is valid.
- `ST_TWO`: both slots are valid.

From any state, the controller moves as follows:
- flush → `ST_EMPTY`.
- Accepted pair in one line → `ST_TWO`.
- Accepted pair split across lines → `ST_ONE`.
- No accepted pair → `ST_EMPTY`.

Top module: `pair_fetch_banks`

## Requirements
- R1: While reset is held, and after it is released with no request, both response valid flags are 0 and both data outputs are 0.
- R2: Bits [7:4] of the first address give the line index L, and bits [3:2] of each address give the bank B of its word. The word stored at (L, B) is 0x5A000000 XOR (L × 0x9E37) XOR (B << 24).
- R3: A pair is accepted when req_valid and req_ready are both 1. If the pair is accepted and bits [31:4] of the two addresses are equal, both valid flags are 1 on the next cycle. rsp_data0 then carries the word for address 0 and rsp_data1 carries the word for address 1.
- R4: If an accepted pair differs in bits [31:4], the next cycle has rsp_valid0 = 1 with the word for address 0, and rsp_valid1 = 0.
- R5: If an accepted pair has two addresses in the same line and the same bank, both slots carry that same word and both are valid.
- R6: In a cycle with no accepted pair, both valid flags are 0 on the next cycle.
- R7: While flush is 1, req_ready is 0 and any offered pair is ignored. Both valid flags are 0 on the following cycle.
- R8: Any slot whose valid flag is 0 drives 0 on its data output.
- R9: rsp_valid1 is never 1 unless rsp_valid0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the store pattern |
| flush | input | 1 | Discard the next response and refuse the pair offered this cycle |
| req_valid | input | 1 | An address pair is offered |
| req_ready | output | 1 | The stage can take a pair this cycle |
| req_addr0 | input | 32 | First fetch address (byte address, word aligned) |
| req_addr1 | input | 32 | Second fetch address (byte address, word aligned) |
| rsp_valid0 | output | 1 | Slot 0 word is valid |
| rsp_data0 | output | 32 | Slot 0 instruction word |
| rsp_valid1 | output | 1 | Slot 1 word is valid |
| rsp_data1 | output | 32 | Slot 1 instruction word |

## Verification
The properties assume that req_valid, flush and both addresses are stable and known at each rising edge. They also assume that reset is held for at least one edge before any request.

The stimulus changes inputs only on falling edges. Flush is raised at random, with or without a pair offered. Address pairs are mostly sequential, and some share a line or are fully random, so split lines, same-bank pairs and aligned pairs all occur.

The line index uses only bits [7:4], so random upper bits exercise the line compare without needing a larger store.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2
    } slot_state_e;

    // Fixed pattern standing in for line storage: line index and bank mixed.
    function automatic logic [31:0] seed_word(input int unsigned line, input int unsigned bank);
        logic [31:0] l32;
        logic [31:0] b32;
        l32 = 32'(line);
        b32 = 32'(bank);
        return 32'h5A00_0000 ^ (l32 * 32'h0000_9E37) ^ (b32 << 24);
    endfunction

endpackage

// File: rtl/pfetch_bank.sv
module pfetch_bank
    import pfetch_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 4,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage loaded with its pattern during reset, held otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(seed_word(i, BANK_ID));
            end
        end
    end

    // One registered read per cycle, enabled by an accepted pair.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/pfetch_line_cmp.sv
module pfetch_line_cmp #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 4
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);

    always_comb begin
        same_line = (addr_a[ADDR_W-1:LINE_LSB] == addr_b[ADDR_W-1:LINE_LSB]);
    end

endmodule

// File: rtl/pfetch_ctrl.sv
module pfetch_ctrl
    import pfetch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic accept,
    input  logic same_line,
    output logic slot0_valid,
    output logic slot1_valid
);

    slot_state_e state_q;
    slot_state_e state_d;

    // Next state: what the output register will hold after this edge.
    always_comb begin
        state_d = ST_EMPTY;
        unique case (state_q)
            ST_EMPTY, ST_ONE, ST_TWO: begin
                if (flush) begin
                    state_d = ST_EMPTY;
                end else if (accept) begin
                    state_d = same_line ? ST_TWO : ST_ONE;
                end else begin
                    state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        slot0_valid = 1'b0;
        slot1_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                slot0_valid = 1'b0;
                slot1_valid = 1'b0;
            end
            ST_ONE: begin
                slot0_valid = 1'b1;
                slot1_valid = 1'b0;
            end
            ST_TWO: begin
                slot0_valid = 1'b1;
                slot1_valid = 1'b1;
            end
            default: begin
                slot0_valid = 1'b0;
                slot1_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pair_fetch_banks.sv
module pair_fetch_banks
    import pfetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BANKS  = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr0,
    input  logic [ADDR_W-1:0] req_addr1,
    output logic              rsp_valid0,
    output logic [DATA_W-1:0] rsp_data0,
    output logic              rsp_valid1,
    output logic [DATA_W-1:0] rsp_data1
);

    localparam int WORD_LSB = $clog2(DATA_W / 8);
    localparam int BANK_W   = $clog2(BANKS);
    localparam int LINE_LSB = WORD_LSB + BANK_W;

    logic                 accept;
    logic                 same_line;
    logic [IDX_W-1:0]     line_idx;
    logic [BANK_W-1:0]    sel0_d;
    logic [BANK_W-1:0]    sel1_d;
    logic [BANK_W-1:0]    sel0_q;
    logic [BANK_W-1:0]    sel1_q;
    logic [DATA_W-1:0]    bank_q [BANKS];
    logic                 v0;
    logic                 v1;

    always_comb begin
        req_ready = ~flush;
        accept    = req_valid & req_ready;
        line_idx  = req_addr0[LINE_LSB +: IDX_W];
        sel0_d    = req_addr0[WORD_LSB +: BANK_W];
        sel1_d    = req_addr1[WORD_LSB +: BANK_W];
    end

    pfetch_line_cmp #(
        .ADDR_W   (ADDR_W),
        .LINE_LSB (LINE_LSB)
    ) u_cmp (
        .addr_a    (req_addr0),
        .addr_b    (req_addr1),
        .same_line (same_line)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        pfetch_bank #(
            .DATA_W  (DATA_W),
            .IDX_W   (IDX_W),
            .BANK_ID (b)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .rd_en  (accept),
            .rd_idx (line_idx),
            .rd_q   (bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel0_q <= '0;
            sel1_q <= '0;
        end else if (accept) begin
            sel0_q <= sel0_d;
            sel1_q <= sel1_d;
        end
    end

    pfetch_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .accept      (accept),
        .same_line   (same_line),
        .slot0_valid (v0),
        .slot1_valid (v1)
    );

    // Slot steering after the bank registers; invalid slots drive zero.
    always_comb begin
        rsp_valid0 = v0;
        rsp_valid1 = v1;
        rsp_data0  = v0 ? bank_q[sel0_q] : '0;
        rsp_data1  = v1 ? bank_q[sel1_q] : '0;
    end

endmodule

// File: rtl/pair_fetch_banks_chk.sv
module pair_fetch_banks_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BANKS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr0,
    input logic [ADDR_W-1:0] req_addr1,
    input logic              rsp_valid0,
    input logic [DATA_W-1:0] rsp_data0,
    input logic              rsp_valid1,
    input logic [DATA_W-1:0] rsp_data1
);

    localparam int LINE_LSB = $clog2(DATA_W / 8) + $clog2(BANKS);

    logic acc;
    logic same;
    always_comb begin
        acc  = req_valid && req_ready;
        same = req_addr0[ADDR_W-1:LINE_LSB] == req_addr1[ADDR_W-1:LINE_LSB];
    end

    assert_match_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && same) |=> (rsp_valid0 && rsp_valid1));

    assert_split_single_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && !same) |=> (rsp_valid0 && !rsp_valid1));

    assert_idle_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (!rsp_valid0 && !rsp_valid1));

    assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        flush |-> !req_ready);

    assert_flush_drops_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rsp_valid0);

    assert_zero_slot0_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid0 |-> (rsp_data0 == '0));

    assert_zero_slot1_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid1 |-> (rsp_data1 == '0));

    assert_order_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid1 |-> rsp_valid0);

endmodule

bind pair_fetch_banks pair_fetch_banks_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANKS  (BANKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr0  (req_addr0),
    .req_addr1  (req_addr1),
    .rsp_valid0 (rsp_valid0),
    .rsp_data0  (rsp_data0),
    .rsp_valid1 (rsp_valid1),
    .rsp_data1  (rsp_data1)
);

// File: tb/tb_pair_fetch_banks.sv
module tb_pair_fetch_banks;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr0 = '0;
    logic [31:0] req_addr1 = '0;
    logic        rsp_valid0;
    logic [31:0] rsp_data0;
    logic        rsp_valid1;
    logic [31:0] rsp_data1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pair_fetch_banks dut (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr0  (req_addr0),
        .req_addr1  (req_addr1),
        .rsp_valid0 (rsp_valid0),
        .rsp_data0  (rsp_data0),
        .rsp_valid1 (rsp_valid1),
        .rsp_data1  (rsp_data1)
    );

    // R2: word at line L (addr0[7:4]) and bank B.
    function automatic logic [31:0] exp_word(input logic [31:0] a0, input logic [1:0] bank);
        logic [31:0] l;
        l = {28'd0, a0[7:4]};
        return 32'h5A00_0000 ^ (l * 32'h0000_9E37) ^ ({30'd0, bank} << 24);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then check the response a cycle later.
    task automatic step(input logic fl, input logic v, input logic [31:0] a0,
                        input logic [31:0] a1, input string req);
        logic acc, pair;
        logic [31:0] e0, e1;
        flush     = fl;
        req_valid = v;
        req_addr0 = a0;
        req_addr1 = a1;
        #1;
        chk({req, " R7 ready"}, {31'd0, req_ready}, {31'd0, ~fl});
        acc  = v && !fl;
        pair = acc && (a0[31:4] == a1[31:4]);
        e0   = acc  ? exp_word(a0, a0[3:2]) : 32'd0;
        e1   = pair ? exp_word(a0, a1[3:2]) : 32'd0;
        @(negedge clk);
        chk({req, " valid0"}, {31'd0, rsp_valid0}, {31'd0, acc});
        chk({req, " valid1"}, {31'd0, rsp_valid1}, {31'd0, pair});
        chk({req, " data0 R2 R8"}, rsp_data0, e0);
        chk({req, " data1 R2 R8"}, rsp_data1, e1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a0, a1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid0 in reset", {31'd0, rsp_valid0}, 32'd0);
        chk("R1 valid1 in reset", {31'd0, rsp_valid1}, 32'd0);
        chk("R1 data0 in reset", rsp_data0, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid0 after reset", {31'd0, rsp_valid0}, 32'd0);
        chk("R1 data1 after reset", rsp_data1, 32'd0);

        step(1'b0, 1'b1, 32'h0000_0100, 32'h0000_0104, "R3 aligned pair");
        step(1'b0, 1'b1, 32'h0000_0138, 32'h0000_013C, "R3 upper banks");
        step(1'b0, 1'b1, 32'h0000_020C, 32'h0000_0210, "R4 cross line");
        step(1'b0, 1'b1, 32'h1234_5670, 32'h0234_5674, "R4 high bits differ");
        step(1'b0, 1'b1, 32'h0000_0048, 32'h0000_0048, "R5 same bank");
        step(1'b0, 1'b1, 32'h0000_00F4, 32'h0000_00F0, "R5 reversed order");
        step(1'b0, 1'b0, 32'h0000_0100, 32'h0000_0104, "R6 no request");
        step(1'b1, 1'b1, 32'h0000_0100, 32'h0000_0104, "R7 flush with request");
        step(1'b1, 1'b0, 32'h0000_0000, 32'h0000_0004, "R7 flush alone");
        step(1'b0, 1'b1, 32'h0000_01F0, 32'h0000_01F4, "R3 after flush");
        // R9 is implied by every valid0/valid1 pair checked above and below.

        for (int n = 0; n < 400; n++) begin
            logic fl, v;
            int sel;
            a0  = $urandom & 32'hFFFF_FFFC;
            sel = $urandom % 10;
            if (sel < 6)      a1 = a0 + 32'd4;
            else if (sel < 8) a1 = {a0[31:4], 2'($urandom), 2'b00};
            else              a1 = $urandom & 32'hFFFF_FFFC;
            fl = ($urandom % 10) == 0;
            v  = ($urandom % 5) != 0;
            step(fl, v, a0, a1, "R3 R4 R6 R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule